// File: doc/BRIEF.md
# Two-Wire Data/Strobe Bit Codec

This block moves a serial bit stream over two wires without a separate clock wire. The transmit side accepts one bit in each clock cycle in which its enable is high. It drives a data wire that always shows the most recent accepted bit. It also drives a companion strobe wire, which flips only when the new bit repeats the previous one. As a result, every accepted bit changes exactly one of the two wires.

The receive side runs on its own clock, which must be at least four times the bit rate. Both wires first pass through a multi-flop synchronizer. The exclusive-OR of the two synchronized wires flips once per bit, so any change in that value marks a bit boundary. At each boundary the receiver captures the synchronized data wire and raises a one-cycle valid pulse. Both sides are fully synchronous and each has its own active-low asynchronous reset.

Top module: `dsLinkCodec`

## Requirements
- R1: While reset is held, the transmit data wire and strobe wire are both 0 and the receive valid output is 0.
- R2: In the cycle after an accepted bit (bitValid high at a rising txClk edge), the data wire equals that bit.
- R3: For each accepted bit, the strobe wire toggles if and only if the data wire keeps its value, so exactly one of the two wires changes.
- R4: While bitValid is low, neither wire changes.
- R5: With the receive clock at four or more times the bit rate, the receiver emits exactly one valid pulse per accepted bit, carrying the bits in the order sent.
- R6: Each receive valid pulse lasts exactly one rxClk cycle.
- R7: The first bit after reset is received whether it is 0 or 1, because the receiver's stored boundary state resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| txClk | input | 1 | Transmit clock |
| txRstN | input | 1 | Transmit asynchronous reset, active low |
| bitIn | input | 1 | Serial bit to send |
| bitValid | input | 1 | Accept bitIn in this cycle |
| dataLine | output | 1 | Transmitted data wire |
| strobeLine | output | 1 | Transmitted strobe wire |
| rxClk | input | 1 | Receive clock |
| rxRstN | input | 1 | Receive asynchronous reset, active low |
| rxDataLine | input | 1 | Incoming data wire |
| rxStrobeLine | input | 1 | Incoming strobe wire |
| rxBit | output | 1 | Recovered bit |
| rxValid | output | 1 | One-cycle pulse when rxBit holds a new bit |

## Verification
The bench builds the block with the default synchronizer depth of two and loops the wires back from the transmitter to the receiver. It varies the transmit clock so that the bit period spans exactly four receive cycles, seven receive cycles, and five to eight receive cycles with idle gaps between bits. The tightest ratio, long runs of equal bits where only the strobe moves, alternating bits where only the data moves, and the first bit after reset with either value are all exercised.

// File: rtl/dsLinkPkg.sv
`timescale 1ns/1ps
package dsLinkPkg;
  // Minimum receive synchronizer depth
  localparam int MIN_SYNC = 2;

  // Strobes from receive control to receive datapath
  typedef struct packed {
    logic capture;  // boundary seen: latch bit, update stored state, pulse valid
  } rxCmd_t;
endpackage

// File: rtl/dsTxEncoder.sv
`timescale 1ns/1ps
module dsTxEncoder (
  input  logic clk,
  input  logic rstN,
  input  logic bitIn,
  input  logic bitValid,
  output logic dataLine,
  output logic strobeLine
);
  logic dataQ;
  logic strobeQ;

  // Data follows the bit; strobe flips only on a repeated bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ   <= 1'b0;
      strobeQ <= 1'b0;
    end else if (bitValid) begin
      dataQ <= bitIn;
      if (bitIn == dataQ) strobeQ <= ~strobeQ;
    end
  end

  assign dataLine   = dataQ;
  assign strobeLine = strobeQ;
endmodule

// File: rtl/dsRxCtrl.sv
`timescale 1ns/1ps
module dsRxCtrl
  import dsLinkPkg::*;
(
  input  logic   curXor,
  input  logic   prevXor,
  output rxCmd_t cmd
);
  // A change of the wire parity marks one bit boundary
  always_comb begin
    cmd.capture = curXor ^ prevXor;
  end
endmodule

// File: rtl/dsRxPath.sv
`timescale 1ns/1ps
module dsRxPath
  import dsLinkPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   dataIn,
  input  logic   strobeIn,
  input  rxCmd_t cmd,
  output logic   curXor,
  output logic   prevXor,
  output logic   rxBit,
  output logic   rxValid
);
  localparam int STAGES = (SYNC_STAGES < MIN_SYNC) ? MIN_SYNC : SYNC_STAGES;
  localparam int TOP    = STAGES - 1;

  logic [TOP:0] dataSync;
  logic [TOP:0] strobeSync;
  logic         prevXorQ;
  logic         rxBitQ;
  logic         rxValidQ;

  // Synchronizer chains, one per wire
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataSync   <= '0;
      strobeSync <= '0;
    end else begin
      dataSync   <= {dataSync[TOP-1:0], dataIn};
      strobeSync <= {strobeSync[TOP-1:0], strobeIn};
    end
  end

  assign curXor = dataSync[TOP] ^ strobeSync[TOP];

  // Capture register and stored parity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevXorQ <= 1'b0;
      rxBitQ   <= 1'b0;
      rxValidQ <= 1'b0;
    end else begin
      rxValidQ <= cmd.capture;
      if (cmd.capture) begin
        prevXorQ <= curXor;
        rxBitQ   <= dataSync[TOP];
      end
    end
  end

  assign prevXor = prevXorQ;
  assign rxBit   = rxBitQ;
  assign rxValid = rxValidQ;
endmodule

// File: rtl/dsLinkCodec.sv
`timescale 1ns/1ps
module dsLinkCodec
  import dsLinkPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic txClk,
  input  logic txRstN,
  input  logic bitIn,
  input  logic bitValid,
  output logic dataLine,
  output logic strobeLine,
  input  logic rxClk,
  input  logic rxRstN,
  input  logic rxDataLine,
  input  logic rxStrobeLine,
  output logic rxBit,
  output logic rxValid
);
  rxCmd_t rxCmd;
  logic   curXor;
  logic   prevXor;

  dsTxEncoder u_tx (
    .clk       (txClk),
    .rstN      (txRstN),
    .bitIn     (bitIn),
    .bitValid  (bitValid),
    .dataLine  (dataLine),
    .strobeLine(strobeLine)
  );

  dsRxCtrl u_rxCtrl (
    .curXor (curXor),
    .prevXor(prevXor),
    .cmd    (rxCmd)
  );

  dsRxPath #(.SYNC_STAGES(SYNC_STAGES)) u_rxPath (
    .clk     (rxClk),
    .rstN    (rxRstN),
    .dataIn  (rxDataLine),
    .strobeIn(rxStrobeLine),
    .cmd     (rxCmd),
    .curXor  (curXor),
    .prevXor (prevXor),
    .rxBit   (rxBit),
    .rxValid (rxValid)
  );
endmodule

// File: rtl/dsLinkChecker.sv
`timescale 1ns/1ps
module dsLinkChecker (
  input logic txClk,
  input logic txRstN,
  input logic bitIn,
  input logic bitValid,
  input logic dataLine,
  input logic strobeLine,
  input logic rxClk,
  input logic rxRstN,
  input logic rxValid
);
  // R2
  data_follows_bit_chk: assert property (@(posedge txClk) disable iff (!txRstN)
    bitValid |=> dataLine == $past(bitIn));

  // R3
  one_wire_moves_chk: assert property (@(posedge txClk) disable iff (!txRstN)
    bitValid |=> (dataLine ^ strobeLine) != $past(dataLine ^ strobeLine));

  // R4
  idle_hold_chk: assert property (@(posedge txClk) disable iff (!txRstN)
    !bitValid |=> $stable(dataLine) && $stable(strobeLine));

  // R6
  single_pulse_chk: assert property (@(posedge rxClk) disable iff (!rxRstN)
    rxValid |=> !rxValid);
endmodule

bind dsLinkCodec dsLinkChecker u_dsLinkChecker (.*);

// File: tb/test_dsLinkCodec.sv
`timescale 1ns/1ps
module test_dsLinkCodec;
  localparam int RX_PERIOD       = 10;
  localparam int WATCHDOG_CYCLES = 100000;
  localparam int MAXBITS         = 1024;

  logic txClk = 1'b0;
  logic rxClk = 1'b0;
  int   txHalf = 20;
  logic txRstN = 1'b0;
  logic rxRstN = 1'b0;
  logic bitIn = 1'b0;
  logic bitValid = 1'b0;
  logic dataLine, strobeLine, rxBit, rxValid;

  int   checks = 0;
  int   errors = 0;
  logic sentBits [MAXBITS];
  logic rcvBits  [MAXBITS];
  int   sentCount = 0;
  int   rcvCount = 0;
  int   wideCount = 0;
  logic lastValid = 1'b0;
  bit   done = 1'b0;

  initial forever #(RX_PERIOD/2) rxClk = ~rxClk;
  initial forever #(txHalf) txClk = ~txClk;

  dsLinkCodec i_dsLinkCodec (
    .txClk       (txClk),
    .txRstN      (txRstN),
    .bitIn       (bitIn),
    .bitValid    (bitValid),
    .dataLine    (dataLine),
    .strobeLine  (strobeLine),
    .rxClk       (rxClk),
    .rxRstN      (rxRstN),
    .rxDataLine  (dataLine),
    .rxStrobeLine(strobeLine),
    .rxBit       (rxBit),
    .rxValid     (rxValid)
  );

  // Collect received bits away from the active edge
  always @(negedge rxClk) begin
    if (!rxRstN) begin
      lastValid = 1'b0;
    end else begin
      if (rxValid) begin
        if (rcvCount < MAXBITS) rcvBits[rcvCount] = rxBit;
        rcvCount++;
        if (lastValid) wideCount++;
      end
      lastValid = rxValid;
    end
  end

  task automatic check(input bit ok, input string req, input int actual,
                       input int expected, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic doReset();
    txRstN = 1'b0;
    rxRstN = 1'b0;
    bitValid = 1'b0;
    bitIn = 1'b0;
    #(8 * txHalf + 4 * RX_PERIOD);
    check(dataLine == 1'b0, "R1", dataLine, 0, "data wire in reset");
    check(strobeLine == 1'b0, "R1", strobeLine, 0, "strobe wire in reset");
    check(rxValid == 1'b0, "R1", rxValid, 0, "valid in reset");
    @(negedge txClk) txRstN = 1'b1;
    @(negedge rxClk) rxRstN = 1'b1;
    sentCount = 0;
    rcvCount = 0;
    wideCount = 0;
    @(negedge txClk);
  endtask

  task automatic startScenario(input int half);
    txHalf = half;
    #(4 * half);
    doReset();
  endtask

  task automatic sendBit(input logic b, input int gap);
    logic pd, ps;
    int   moved;
    pd = dataLine;
    ps = strobeLine;
    bitIn = b;
    bitValid = 1'b1;
    if (sentCount < MAXBITS) sentBits[sentCount] = b;
    sentCount++;
    @(negedge txClk);
    check(dataLine == b, "R2", dataLine, b, "data wire after bit");
    moved = int'(dataLine != pd) + int'(strobeLine != ps);
    check(moved == 1, "R3", moved, 1, "wires changed per bit");
    check((strobeLine != ps) == (b == pd), "R3", strobeLine, int'(ps ^ (b == pd)),
          "strobe toggle rule");
    bitValid = 1'b0;
    for (int i = 0; i < gap; i++) begin
      pd = dataLine;
      ps = strobeLine;
      @(negedge txClk);
      check(dataLine == pd && strobeLine == ps, "R4", {dataLine, strobeLine},
            {pd, ps}, "wires held while idle");
    end
  endtask

  task automatic finishScenario(input string name);
    int bad;
    #(30 * RX_PERIOD + 8 * txHalf);
    check(rcvCount == sentCount, "R5", rcvCount, sentCount, {name, " bit count"});
    bad = -1;
    for (int i = 0; i < sentCount && i < rcvCount && i < MAXBITS; i++)
      if (bad < 0 && rcvBits[i] != sentBits[i]) bad = i;
    check(bad < 0, "R5", bad, -1, {name, " first mismatching bit index"});
    check(wideCount == 0, "R6", wideCount, 0, {name, " valid pulses wider than one cycle"});
  endtask

  task automatic testReset();
    txHalf = 20;
    doReset();
  endtask

  task automatic testFirstBit();
    for (int v = 0; v < 2; v++) begin
      startScenario(20);
      sendBit(v[0], 0);
      #(30 * RX_PERIOD + 8 * txHalf);
      check(rcvCount == 1, "R7", rcvCount, 1, "first bit received once");
      check(rcvBits[0] == v[0], "R7", rcvBits[0], v, "first bit value");
    end
  endtask

  task automatic testAlternating();
    startScenario(20);
    for (int i = 0; i < 64; i++) sendBit(i[0], 0);
    finishScenario("alternating");
  endtask

  task automatic testLongRuns();
    startScenario(35);
    for (int i = 0; i < 40; i++) sendBit(1'b1, 0);
    for (int i = 0; i < 40; i++) sendBit(1'b0, 0);
    for (int i = 0; i < 3; i++) sendBit(1'b1, 0);
    finishScenario("long runs");
  endtask

  task automatic testGaps();
    startScenario(5);
    for (int i = 0; i < 80; i++) sendBit(1'($urandom), int'($urandom_range(7, 4)));
    finishScenario("idle gaps");
  endtask

  task automatic testRandom();
    startScenario(20);
    for (int i = 0; i < 200; i++) sendBit(1'($urandom), 0);
    finishScenario("random 4x");
  endtask

  task automatic endRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge rxClk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
    endRun();
  end

  initial begin
    testReset();
    testFirstBit();
    testAlternating();
    testLongRuns();
    testGaps();
    testRandom();
    endRun();
  end
endmodule